// File: doc/BRIEF.md
# Two-Stage Serial Baud Tick Generator

This block makes the timing enables for an asynchronous serial port from the internal bus clock. The bus clock is the oscillator divided by four. Two dividers run in series. The first is a prescaler that can divide by odd or even ratios. The second divides further by a power of two. The output of the chain is a receive sampling tick at sixteen times the bit rate. A last divide-by-16 stage turns that tick into a transmit bit-rate tick.

Both outputs are enable pulses in the bus clock domain, not derived clocks. Shift logic elsewhere qualifies its flops with them. Two registered select fields set the ratio. The prescale code returns to 00 on reset, while the rate code is held through reset. A change to either code restarts the counter of its own stage, so that counter never runs past a smaller new terminal count. The final ÷16 stage keeps its phase when a code changes.

Top module: `serial_tick_gen`

## Requirements
- R1: The prescale code on `pre_sel` sets a divide ratio P. Code 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R2: The rate code n on `rate_sel` divides by a further 2^n. While both codes are held, consecutive `rx_tick` pulses are P·2^n cycles apart, or `rx_tick` stays high when P·2^n is 1.
- R3: `tx_tick` is high only in a cycle where `rx_tick` is also high, on every sixteenth `rx_tick`. While both codes are held, `tx_tick` pulses are 16·P·2^n cycles apart.
- R4: `tx_tick` is one cycle wide. `rx_tick` is one cycle wide whenever P·2^n is greater than 1.
- R5: While `rst_n` is low, both outputs are low. With both codes at 0 through the release of reset, `rx_tick` is high after the first rising edge that follows the release, and `tx_tick` first rises after the sixteenth such edge.
- R6: When a code changes, its stage counter restarts and `rx_tick` is low in the cycle after the change. When both codes change together, the first new `rx_tick` follows the (P·2^n+1)-th rising edge that comes after the change.
- R7: Code changes do not restart the final ÷16 stage. The transmit phase carries on from its count before the change, and the prescale code reads as 00 directly after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | Prescale code (00 ÷1, 01 ÷3, 10 ÷4, 11 ÷13) |
| rate_sel | input | RATE_SEL_W (3) | Power-of-two rate code n, divide by 2^n |
| rx_tick | output | 1 | 16x receive sampling enable |
| tx_tick | output | 1 | 1x transmit bit enable |

## Verification
The hardest case to reach is the longest chain, ÷13 with ÷128. Here a transmit interval takes 26,624 cycles, and the ÷16 stage enters each new setting at whatever phase the last one left it. The stimulus walks through all 32 code pairs in order. For each pair it waits for one transmit tick to line up and then times a full transmit interval, along with the receive gap inside it. A behavioural model follows every cycle, so the restarts caused by each code change and the carried-over transmit phase are compared at every edge. A separate step changes both codes at once and counts the edges to the first new receive tick.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;

   localparam int PRE_SEL_W = 2;
   localparam int PRE_CNT_W = 4;

   // terminal count (ratio - 1) of the prescale stage for each code
   function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [PRE_SEL_W-1:0] code);
      case (code)
         2'd0:    return 4'd0;
         2'd1:    return 4'd2;
         2'd2:    return 4'd3;
         default: return 4'd12;
      endcase
   endfunction

endpackage

// File: rtl/tick_sel_hold.sv
module tick_sel_hold #(
   parameter int W             = 2,
   parameter bit KEEP_ON_RESET = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         chg
);

   generate
      if (W < 1) begin : g_bad_width
         $error("tick_sel_hold: W must be at least 1");
      end

      if (KEEP_ON_RESET) begin : g_keep
         always_ff @(posedge clk) begin
            q <= d;
         end
      end else begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end
   endgenerate

   assign chg = rst_n && (d != q);

endmodule

// File: rtl/tick_stage_div.sv
module tick_stage_div #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             restart,
   input  logic [CNT_W-1:0] last,
   output logic             wrap
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("tick_stage_div: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             at_last;

   assign at_last = (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= at_last ? '0 : cnt + 1'b1;
      end
   end

   assign wrap = adv && !restart && at_last;

endmodule

// File: rtl/tick_out_stage.sv
module tick_out_stage #(
   parameter int N          = 2,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   generate
      if (N < 1) begin : g_bad_n
         $error("tick_out_stage: N must be at least 1");
      end

      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_comb
         assign q = rst_n ? d : '0;
      end
   endgenerate

endmodule

// File: rtl/serial_tick_gen.sv
module serial_tick_gen
   import tick_gen_pkg::*;
#(
   parameter int RATE_SEL_W  = 3,
   parameter int TX_DIV_LOG2 = 4,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PRE_SEL_W-1:0]  pre_sel,
   input  logic [RATE_SEL_W-1:0] rate_sel,
   output logic                  rx_tick,
   output logic                  tx_tick
);

   localparam int RATE_CNT_W = (1 << RATE_SEL_W) - 1;

   generate
      if (RATE_SEL_W < 1 || RATE_SEL_W > 5) begin : g_bad_rate_w
         $error("serial_tick_gen: RATE_SEL_W must be 1..5");
      end
      if (TX_DIV_LOG2 < 1 || TX_DIV_LOG2 > 8) begin : g_bad_tx_div
         $error("serial_tick_gen: TX_DIV_LOG2 must be 1..8");
      end
   endgenerate

   // select capture: prescale code clears, rate code survives reset
   logic [PRE_SEL_W-1:0]  pre_q;
   logic                  pre_chg;
   logic [RATE_SEL_W-1:0] rate_q;
   logic                  rate_chg;

   tick_sel_hold #(.W(PRE_SEL_W), .KEEP_ON_RESET(1'b0)) u_pre_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pre_sel),
      .q     (pre_q),
      .chg   (pre_chg)
   );

   tick_sel_hold #(.W(RATE_SEL_W), .KEEP_ON_RESET(1'b1)) u_rate_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rate_sel),
      .q     (rate_q),
      .chg   (rate_chg)
   );

   // stage 1: prescaler, advances every bus cycle
   logic [PRE_CNT_W-1:0] pre_last_cnt;
   logic                 pre_tick;

   assign pre_last_cnt = pre_last(pre_q);

   tick_stage_div #(.CNT_W(PRE_CNT_W)) u_pre_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (1'b1),
      .restart (pre_chg),
      .last    (pre_last_cnt),
      .wrap    (pre_tick)
   );

   // stage 2: binary submultiple, advances on prescaler ticks
   logic [RATE_CNT_W-1:0] rate_one;
   logic [RATE_CNT_W-1:0] rate_last_cnt;
   logic                  rx_tick_c;

   assign rate_one      = {{(RATE_CNT_W-1){1'b0}}, 1'b1};
   assign rate_last_cnt = (rate_one << rate_q) - rate_one;

   tick_stage_div #(.CNT_W(RATE_CNT_W)) u_rate_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (pre_tick),
      .restart (rate_chg),
      .last    (rate_last_cnt),
      .wrap    (rx_tick_c)
   );

   // stage 3: fixed 1x divider, never restarted by code changes
   logic [TX_DIV_LOG2-1:0] tx_last_cnt;
   logic                   tx_tick_c;

   assign tx_last_cnt = '1;

   tick_stage_div #(.CNT_W(TX_DIV_LOG2)) u_tx_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (rx_tick_c),
      .restart (1'b0),
      .last    (tx_last_cnt),
      .wrap    (tx_tick_c)
   );

   logic [1:0] ticks_q;

   tick_out_stage #(.N(2), .REGISTERED(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({tx_tick_c, rx_tick_c}),
      .q     (ticks_q)
   );

   assign rx_tick = ticks_q[0];
   assign tx_tick = ticks_q[1];

endmodule

// File: rtl/serial_tick_gen_chk.sv
module serial_tick_gen_chk #(
   parameter int RATE_SEL_W = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            pre_sel,
   input logic [RATE_SEL_W-1:0] rate_sel,
   input logic                  rx_tick,
   input logic                  tx_tick
);

   // R5: reset holds both enables low
   p_reset_quiet_r5: assert property (@(posedge clk)
      !rst_n |=> (!rx_tick && !tx_tick));

   // R3: a transmit tick always lands on a receive tick
   p_tx_on_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |-> rx_tick);

   // R4: transmit tick is a single-cycle pulse
   p_tx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |=> !tx_tick);

   // R2: with a held nonzero rate code, receive ticks are never adjacent
   p_rx_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_tick && rate_sel != '0 && $stable(rate_sel)) |=> !rx_tick);

   // R6: a code change suppresses the next receive tick
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(pre_sel) || !$stable(rate_sel)) |=> !rx_tick);

endmodule

bind serial_tick_gen serial_tick_gen_chk #(.RATE_SEL_W(RATE_SEL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pre_sel  (pre_sel),
   .rate_sel (rate_sel),
   .rx_tick  (rx_tick),
   .tx_tick  (tx_tick)
);

// File: tb/tb_serial_tick_gen.sv
`timescale 1ns/1ps
module tb_serial_tick_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pre_sel = 2'd0;
   logic [2:0] rate_sel = 3'd0;
   logic       rx_tick;
   logic       tx_tick;

   int    checks = 0;
   int    errors = 0;
   longint cyc = 0;
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   serial_tick_gen dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pre_sel  (pre_sel),
      .rate_sel (rate_sel),
      .rx_tick  (rx_tick),
      .tx_tick  (tx_tick)
   );

   function automatic int ratio(input int code);
      case (code)
         0:       return 1;
         1:       return 3;
         2:       return 4;
         default: return 13;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference: countdown per stage, fed by sampled inputs
   int mp = 0, mr = 0, p_left = 1, r_left = 1, t_left = 16;
   bit m_rx = 1'b0, m_tx = 1'b0;

   always @(posedge clk) begin
      bit ph, rh, th;
      cyc++;
      ph = 1'b0; rh = 1'b0; th = 1'b0;
      if (!rst_n) begin
         mp = 0; mr = int'(rate_sel);
         p_left = 1; r_left = 1; t_left = 16;
      end else begin
         if (int'(pre_sel) != mp) begin
            mp = int'(pre_sel); p_left = ratio(mp);
         end else begin
            p_left--;
            if (p_left == 0) begin ph = 1'b1; p_left = ratio(mp); end
         end
         if (int'(rate_sel) != mr) begin
            mr = int'(rate_sel); r_left = 1 << mr;
         end else if (ph) begin
            r_left--;
            if (r_left == 0) begin rh = 1'b1; r_left = 1 << mr; end
         end
         if (rh) begin
            t_left--;
            if (t_left == 0) begin th = 1'b1; t_left = 16; end
         end
      end
      m_rx = rh;
      m_tx = th;
   end

   always @(negedge clk) begin
      if (!done) begin
         check(rx_tick === m_rx, "R2", "rx_tick vs model", longint'(rx_tick), longint'(m_rx));
         check(tx_tick === m_tx, "R3 R7", "tx_tick vs model", longint'(tx_tick), longint'(m_tx));
      end
   end

   always @(posedge clk) begin
      if (!done && cyc > 195000) begin
         done = 1'b1;
         errors++;
         $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 195000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      int n;
      int last;
      int gap;
      int d;

      // R5: quiet while in reset
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(!rx_tick && !tx_tick, "R5", "outputs in reset",
               longint'({tx_tick, rx_tick}), 0);
      end
      rst_n = 1'b1;
      step();
      check(rx_tick == 1'b1, "R5", "rx after first edge", longint'(rx_tick), 1);
      n = 1;
      while (!tx_tick && n < 100) begin step(); n++; end
      check(n == 16, "R5", "edges to first tx", n, 16);
      step();
      check(tx_tick == 1'b0, "R4", "tx width", longint'(tx_tick), 0);

      // R6: both codes change together
      pre_sel = 2'd2; rate_sel = 3'd3;
      step();
      check(rx_tick == 1'b0, "R6", "rx after change", longint'(rx_tick), 0);
      n = 1;
      while (!rx_tick && n < 1000) begin step(); n++; end
      check(n == 4 * 8 + 1, "R6", "edges to first rx", n, 4 * 8 + 1);

      // R1 R2 R3: every code pair
      for (int p = 0; p < 4; p++) begin
         for (int r = 0; r < 8; r++) begin
            pre_sel = 2'(p); rate_sel = 3'(r);
            d = ratio(p) << r;
            n = 0;
            step();
            while (!tx_tick && n < 60000) begin step(); n++; end
            n = 0; last = 0; gap = 0;
            do begin
               step(); n++;
               if (rx_tick) begin gap = n - last; last = n; end
            end while (!tx_tick && n < 60000);
            check(gap == d, "R1 R2", $sformatf("rx gap p=%0d r=%0d", p, r), gap, d);
            check(n == 16 * d, "R3", $sformatf("tx gap p=%0d r=%0d", p, r), n, 16 * d);
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule